// File: doc/BRIEF.md
# Hybrid TDMA, Priority and Round-Robin Memory Arbiter

This block decides which of sixteen requesting agents owns a shared memory port next. It grants one transaction at a time. A granted agent keeps the port until the memory side pulses transaction-done. Three schemes are stacked in fixed precedence. A 128-slot time-division wheel comes first and bounds the worst-case latency of the agents placed on it. A 16-entry priority list comes second and secures bandwidth for the agents it names. Two chained round-robin levels come last and share what remains among best-effort agents. The first round-robin level has 16 entries. Its final entry stands for the whole 8-entry second level.

Software programs all tables through a simple write port. Two complete parameter sets are held, each with a wheel, a priority list and both round-robin lists, and a control word selects the active one. Out of reset the arbiter is in boot mode, where it serves every requester in plain rotating order. Setting the enable bit moves it onto the programmed tables. Changes to the set select and the enable bit are applied only between transactions. Wheel entries use a shifted agent numbering: the wheel code equals the agent number plus 8, modulo 16. List entries use the plain agent number.

Top module: `hybrid_mem_arb`

## Requirements
- R1: While rst_ni is low and after its release with no request, gnt_o is 0, gnt_valid_o is 0 and gnt_id_o is 0.
- R2: In boot mode (enable bit 0, the reset state) the grant goes to the first requesting agent at or after a rotating pointer. The pointer is 0 after reset and moves to the granted agent plus 1, modulo 16.
- R3: While gnt_valid_o is 1, gnt_o has exactly one bit set, at position gnt_id_o; while it is 0, gnt_o is 0.
- R4: A grant holds unchanged until done_i is sampled high. The grant is dropped on the next cycle, and a new grant can appear no earlier than the cycle after that.
- R5: A grant is issued only to an agent whose request bit was high in the cycle the decision was made. With no request, no grant is issued.
- R6: In scheduled mode, a valid wheel entry at the current slot wins over all else when its agent requests. The entry's 4-bit code names agent (code + 8) mod 16.
- R7: In scheduled mode the wheel slot pointer starts at 0, advances by one on each completed transaction, and wraps from 127 to 0.
- R8: When the wheel does not win, the grant goes to the lowest-index valid priority entry whose agent requests. Index 0 has the highest priority.
- R9: When neither the wheel nor the priority list wins, first-level round-robin entries 0..14 are scanned from a pointer that moves to one past the winning entry.
- R10: First-level entry 15 ignores its data and counts as requesting when any valid second-level entry's agent requests. When it wins, the second level picks by its own rotating pointer, and the first-level pointer wraps to 0.
- R11: A control write takes effect at the next decision made with no transaction active; during an active grant the grant is unaffected.
- R12: Writes to the inactive parameter set do not change which agent is granted.
- R13: Address map of cfg_addr_i[8:0]: bit 8 picks set 0/1. If bit 7 is 1, bits 6:0 are the wheel slot. Otherwise bits 6:5 pick the table (0 priority, 1 first-level round-robin, 2 second-level round-robin, 3 control) and bits 4:0 the entry; out-of-range entries are ignored. Table data is {valid = bit 4, id = bits 3:0}. Control data is bit 0 = set select and bit 1 = enable; it ignores address bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request bit per agent |
| done_i | input | 1 | Pulse ending the granted transaction |
| cfg_we_i | input | 1 | Table or control write strobe |
| cfg_addr_i | input | 9 | Write address (see R13) |
| cfg_wdata_i | input | 5 | Write data (see R13) |
| gnt_o | output | 16 | One-hot grant |
| gnt_id_o | output | 4 | Number of the granted agent |
| gnt_valid_o | output | 1 | A transaction is granted and active |

## Verification
The checker watches the grant handshake on every cycle: the one-hot shape of the grant and its agreement with the encoded ID, the grant holding until done, the drop after done, and that no agent is granted unless it requested. Which agent wins depends on programmed tables, pointers and mode. That can only be shown by the bench's scenarios, which cover the boot rotation with wrap, the wheel ID shift and the wheel wrap at slot 127, priority order, both round-robin levels and the hand-over between them, and set switching requested during an active grant.

// File: rtl/hma_pkg.sv
package hma_pkg;
  localparam int ID_W   = 4;
  localparam int AGENTS = 1 << ID_W;
  localparam int DATA_W = ID_W + 1;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
  } ent_t;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_BOOT, SRC_WHEEL, SRC_PRIO, SRC_RR1, SRC_RR2
  } src_e;

  // wheel codes are offset by half the ID space
  function automatic logic [ID_W-1:0] wheel_to_agent(input logic [ID_W-1:0] code);
    return code + ID_W'(AGENTS / 2);
  endfunction
endpackage

// File: rtl/hma_cfg_store.sv
module hma_cfg_store
  import hma_pkg::*;
#(
  parameter int WHEEL_SLOTS = 128,
  parameter int PRIO_N      = 16,
  parameter int RR1_N       = 16,
  parameter int RR2_N       = 8,
  localparam int WHEEL_W    = $clog2(WHEEL_SLOTS),
  localparam int CFG_AW     = WHEEL_W + 2,
  localparam int LIDX_W     = WHEEL_W - 2,
  localparam int PI_W       = $clog2(PRIO_N),
  localparam int R1_W       = $clog2(RR1_N),
  localparam int R2_W       = $clog2(RR2_N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CFG_AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    sel_i,
  input  logic [WHEEL_W-1:0]      wheel_ptr_i,
  output ent_t                    wheel_ent_o,
  output ent_t [PRIO_N-1:0]       prio_o,
  output ent_t [RR1_N-1:0]        rr1_o,
  output ent_t [RR2_N-1:0]        rr2_o,
  output logic                    pend_sel_o,
  output logic                    pend_en_o
);
  ent_t              wheel_q [2][WHEEL_SLOTS];
  ent_t [PRIO_N-1:0] prio_q  [2];
  ent_t [RR1_N-1:0]  rr1_q   [2];
  ent_t [RR2_N-1:0]  rr2_q   [2];
  logic              sel_q, en_q;

  logic              set_b, is_wheel;
  logic [1:0]        tbl;
  logic [LIDX_W-1:0] lidx;
  logic [WHEEL_W-1:0] slot;
  ent_t              went;
  logic              unused_bits;

  assign set_b    = addr_i[CFG_AW-1];
  assign is_wheel = addr_i[CFG_AW-2];
  assign slot     = addr_i[WHEEL_W-1:0];
  assign tbl      = addr_i[WHEEL_W-1 -: 2];
  assign lidx     = addr_i[LIDX_W-1:0];
  assign went     = ent_t'(wdata_i);
  assign unused_bits = ^wdata_i[DATA_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < WHEEL_SLOTS; i++) wheel_q[s][i] <= '0;
        prio_q[s] <= '0;
        rr1_q[s]  <= '0;
        rr2_q[s]  <= '0;
      end
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (we_i) begin
      if (is_wheel) begin
        wheel_q[set_b][slot] <= went;
      end else begin
        unique case (tbl)
          2'd0: if (32'(lidx) < PRIO_N) prio_q[set_b][lidx[PI_W-1:0]] <= went;
          2'd1: if (32'(lidx) < RR1_N)  rr1_q[set_b][lidx[R1_W-1:0]]  <= went;
          2'd2: if (32'(lidx) < RR2_N)  rr2_q[set_b][lidx[R2_W-1:0]]  <= went;
          default: begin
            sel_q <= wdata_i[0];
            en_q  <= wdata_i[1];
          end
        endcase
      end
    end
  end

  assign wheel_ent_o = wheel_q[sel_i][wheel_ptr_i];
  assign prio_o      = prio_q[sel_i];
  assign rr1_o       = rr1_q[sel_i];
  assign rr2_o       = rr2_q[sel_i];
  assign pend_sel_o  = sel_q;
  assign pend_en_o   = en_q;
endmodule

// File: rtl/hma_rr_scan.sv
module hma_rr_scan #(
  parameter int N  = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = int'(ptr_i) + k;
      if (p >= N) p = p - N;
      if (!hit_o && req_i[p]) begin
        hit_o = 1'b1;
        idx_o = W'(p);
      end
    end
  end
endmodule

// File: rtl/hma_pick.sv
module hma_pick
  import hma_pkg::*;
#(
  parameter int PRIO_N = 16,
  parameter int RR1_N  = 16,
  parameter int RR2_N  = 8,
  localparam int R1_W  = $clog2(RR1_N),
  localparam int R2_W  = $clog2(RR2_N)
) (
  input  logic [AGENTS-1:0] req_i,
  input  logic              en_i,
  input  ent_t              wheel_ent_i,
  input  ent_t [PRIO_N-1:0] prio_i,
  input  ent_t [RR1_N-1:0]  rr1_i,
  input  ent_t [RR2_N-1:0]  rr2_i,
  input  logic [ID_W-1:0]   boot_ptr_i,
  input  logic [R1_W-1:0]   rr1_ptr_i,
  input  logic [R2_W-1:0]   rr2_ptr_i,
  output logic              win_vld_o,
  output logic [ID_W-1:0]   win_id_o,
  output src_e              src_o,
  output logic [R1_W-1:0]   rr1_idx_o,
  output logic [R2_W-1:0]   rr2_idx_o
);
  logic [RR1_N-1:0] rr1_req;
  logic [RR2_N-1:0] rr2_req;
  logic             boot_hit, rr1_hit, rr2_hit, wheel_hit, prio_hit;
  logic [ID_W-1:0]  boot_idx, wheel_agent, prio_id;
  logic             unused_gw;

  for (genvar j = 0; j < RR2_N; j++) begin : g_rr2_req
    assign rr2_req[j] = rr2_i[j].vld && req_i[rr2_i[j].id];
  end
  for (genvar k = 0; k < RR1_N - 1; k++) begin : g_rr1_req
    assign rr1_req[k] = rr1_i[k].vld && req_i[rr1_i[k].id];
  end
  // last first-level entry is the gateway to the second level
  assign rr1_req[RR1_N-1] = |rr2_req;
  assign unused_gw = ^rr1_i[RR1_N-1];

  hma_rr_scan #(.N(AGENTS)) u_boot (
    .req_i(req_i), .ptr_i(boot_ptr_i), .hit_o(boot_hit), .idx_o(boot_idx));
  hma_rr_scan #(.N(RR1_N)) u_rr1 (
    .req_i(rr1_req), .ptr_i(rr1_ptr_i), .hit_o(rr1_hit), .idx_o(rr1_idx_o));
  hma_rr_scan #(.N(RR2_N)) u_rr2 (
    .req_i(rr2_req), .ptr_i(rr2_ptr_i), .hit_o(rr2_hit), .idx_o(rr2_idx_o));

  assign wheel_agent = wheel_to_agent(wheel_ent_i.id);
  assign wheel_hit   = wheel_ent_i.vld && req_i[wheel_agent];

  always_comb begin
    prio_hit = 1'b0;
    prio_id  = '0;
    for (int k = 0; k < PRIO_N; k++) begin
      if (!prio_hit && prio_i[k].vld && req_i[prio_i[k].id]) begin
        prio_hit = 1'b1;
        prio_id  = prio_i[k].id;
      end
    end
  end

  always_comb begin
    win_vld_o = 1'b0;
    win_id_o  = '0;
    src_o     = SRC_NONE;
    if (!en_i) begin
      if (boot_hit) begin
        win_vld_o = 1'b1; win_id_o = boot_idx; src_o = SRC_BOOT;
      end
    end else if (wheel_hit) begin
      win_vld_o = 1'b1; win_id_o = wheel_agent; src_o = SRC_WHEEL;
    end else if (prio_hit) begin
      win_vld_o = 1'b1; win_id_o = prio_id; src_o = SRC_PRIO;
    end else if (rr1_hit) begin
      win_vld_o = 1'b1;
      if (rr1_idx_o == R1_W'(RR1_N - 1)) begin
        win_id_o = rr2_i[rr2_idx_o].id; src_o = SRC_RR2;
      end else begin
        win_id_o = rr1_i[rr1_idx_o].id; src_o = SRC_RR1;
      end
    end
  end

  logic unused_rr2;
  assign unused_rr2 = rr2_hit;
endmodule

// File: rtl/hybrid_mem_arb.sv
module hybrid_mem_arb
  import hma_pkg::*;
#(
  parameter int WHEEL_SLOTS = 128,
  parameter int PRIO_N      = 16,
  parameter int RR1_N       = 16,
  parameter int RR2_N       = 8,
  localparam int WHEEL_W    = $clog2(WHEEL_SLOTS),
  localparam int CFG_AW     = WHEEL_W + 2,
  localparam int R1_W       = $clog2(RR1_N),
  localparam int R2_W       = $clog2(RR2_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AGENTS-1:0]   req_i,
  input  logic                done_i,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [AGENTS-1:0]   gnt_o,
  output logic [ID_W-1:0]     gnt_id_o,
  output logic                gnt_valid_o
);
  logic               busy_q;
  logic [ID_W-1:0]    gnt_id_q;
  logic               act_sel_q, act_en_q;
  logic               pend_sel, pend_en, eff_sel, eff_en;
  logic [WHEEL_W-1:0] wheel_ptr_q;
  logic [ID_W-1:0]    boot_ptr_q;
  logic [R1_W-1:0]    rr1_ptr_q, rr1_idx;
  logic [R2_W-1:0]    rr2_ptr_q, rr2_idx;
  ent_t               wheel_ent;
  ent_t [PRIO_N-1:0]  prio;
  ent_t [RR1_N-1:0]   rr1;
  ent_t [RR2_N-1:0]   rr2;
  logic               win_vld;
  logic [ID_W-1:0]    win_id;
  src_e               src;

  // newest control applies at idle, frozen while a grant is active
  assign eff_sel = busy_q ? act_sel_q : pend_sel;
  assign eff_en  = busy_q ? act_en_q  : pend_en;

  hma_cfg_store #(
    .WHEEL_SLOTS(WHEEL_SLOTS), .PRIO_N(PRIO_N), .RR1_N(RR1_N), .RR2_N(RR2_N)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .sel_i(eff_sel), .wheel_ptr_i(wheel_ptr_q),
    .wheel_ent_o(wheel_ent), .prio_o(prio), .rr1_o(rr1), .rr2_o(rr2),
    .pend_sel_o(pend_sel), .pend_en_o(pend_en)
  );

  hma_pick #(.PRIO_N(PRIO_N), .RR1_N(RR1_N), .RR2_N(RR2_N)) u_pick (
    .req_i, .en_i(eff_en), .wheel_ent_i(wheel_ent),
    .prio_i(prio), .rr1_i(rr1), .rr2_i(rr2),
    .boot_ptr_i(boot_ptr_q), .rr1_ptr_i(rr1_ptr_q), .rr2_ptr_i(rr2_ptr_q),
    .win_vld_o(win_vld), .win_id_o(win_id), .src_o(src),
    .rr1_idx_o(rr1_idx), .rr2_idx_o(rr2_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      gnt_id_q    <= '0;
      act_sel_q   <= 1'b0;
      act_en_q    <= 1'b0;
      wheel_ptr_q <= '0;
      boot_ptr_q  <= '0;
      rr1_ptr_q   <= '0;
      rr2_ptr_q   <= '0;
    end else if (!busy_q) begin
      act_sel_q <= pend_sel;
      act_en_q  <= pend_en;
      if (win_vld) begin
        busy_q   <= 1'b1;
        gnt_id_q <= win_id;
        unique case (src)
          SRC_BOOT: boot_ptr_q <= win_id + 1'b1;
          SRC_RR1:  rr1_ptr_q  <= (rr1_idx == R1_W'(RR1_N - 1)) ? '0 : rr1_idx + 1'b1;
          SRC_RR2: begin
            rr1_ptr_q <= '0;
            rr2_ptr_q <= (rr2_idx == R2_W'(RR2_N - 1)) ? '0 : rr2_idx + 1'b1;
          end
          default: ;
        endcase
      end
    end else if (done_i) begin
      busy_q <= 1'b0;
      if (act_en_q)
        wheel_ptr_q <= (wheel_ptr_q == WHEEL_W'(WHEEL_SLOTS - 1)) ? '0 : wheel_ptr_q + 1'b1;
    end
  end

  assign gnt_valid_o = busy_q;
  assign gnt_id_o    = gnt_id_q;
  assign gnt_o       = busy_q ? (AGENTS'(1) << gnt_id_q) : '0;
endmodule

// File: rtl/hma_chk.sv
module hma_chk
  import hma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AGENTS-1:0] req_i,
  input logic              done_i,
  input logic [AGENTS-1:0] gnt_o,
  input logic [ID_W-1:0]   gnt_id_o,
  input logic              gnt_valid_o
);
  // R3
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ($countones(gnt_o) == 1) && gnt_o[gnt_id_o]);
  // R3
  gnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_valid_o |-> (gnt_o == '0));
  // R4
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !done_i) |=> gnt_valid_o && $stable(gnt_o));
  // R4
  gnt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);
  // R5
  gnt_requested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> |($past(req_i) & gnt_o));
  // R5
  no_req_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && (req_i == '0)) |=> !gnt_valid_o);
endmodule

bind hybrid_mem_arb hma_chk u_chk (.*);

// File: tb/hybrid_mem_arb_test.sv
module hybrid_mem_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        done = 1'b0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [4:0]  wdata = '0;
  logic [15:0] gnt;
  logic [3:0]  gnt_id;
  logic        gnt_valid;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hybrid_mem_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .gnt_o(gnt), .gnt_id_o(gnt_id), .gnt_valid_o(gnt_valid)
  );

  // boot-mode vectors {req, expected id}
  localparam logic [19:0] BOOT_VEC [9] = '{
    {16'hFFFF, 4'd0}, {16'hFFFF, 4'd1}, {16'h0001, 4'd0},
    {16'h8001, 4'd15}, {16'h8001, 4'd0}, {16'h0010, 4'd4},
    {16'h0011, 4'd0}, {16'h0006, 4'd1}, {16'h0006, 4'd2}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [4:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_gnt();
    for (int i = 0; i < 8 && !gnt_valid; i++) @(negedge clk);
  endtask

  task automatic finish_txn(input string tag);
    done = 1'b1; req = '0;
    @(negedge clk); done = 1'b0;
    check(!gnt_valid && gnt == '0, {tag, " R4 release"}, int'(gnt_valid), 0);
  endtask

  task automatic txn(input logic [15:0] r, input logic [3:0] exp, input string tag);
    @(negedge clk); req = r;
    wait_gnt();
    check(gnt_valid && gnt_id == exp, tag, int'(gnt_id), int'(exp));
    check(gnt == (16'h1 << exp), {tag, " R3 onehot"}, int'(gnt), int'(16'h1 << exp));
    finish_txn(tag);
  endtask

  // address helpers per R13
  function automatic logic [8:0] a_wheel(input logic s, input logic [6:0] slot);
    return {s, 1'b1, slot};
  endfunction
  function automatic logic [8:0] a_tbl(input logic s, input logic [1:0] t, input logic [4:0] i);
    return {s, 1'b0, t, i};
  endfunction

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(gnt == '0 && !gnt_valid && gnt_id == '0, "R1 in reset", int'(gnt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(gnt == '0 && !gnt_valid, "R1 after release", int'(gnt_valid), 0);
    check(!gnt_valid, "R5 no request no grant", int'(gnt_valid), 0);

    // R2 boot rotation
    for (int v = 0; v < 9; v++)
      txn(BOOT_VEC[v][19:4], BOOT_VEC[v][3:0], $sformatf("R2 boot vec %0d", v));

    // program set 0 (R13)
    wr(a_wheel(1'b0, 7'd0),   5'h1B);   // agent 3 -> code 0xB
    wr(a_wheel(1'b0, 7'd127), 5'h1C);   // agent 4 -> code 0xC
    wr(a_tbl(1'b0, 2'd0, 5'd0), 5'h15);
    wr(a_tbl(1'b0, 2'd0, 5'd1), 5'h12);
    wr(a_tbl(1'b0, 2'd1, 5'd0), 5'h17);
    wr(a_tbl(1'b0, 2'd1, 5'd1), 5'h19);
    wr(a_tbl(1'b0, 2'd1, 5'd2), 5'h1A);
    wr(a_tbl(1'b0, 2'd2, 5'd0), 5'h1C);
    wr(a_tbl(1'b0, 2'd2, 5'd1), 5'h1D);
    wr(a_tbl(1'b0, 2'd3, 5'd0), 5'b00010); // enable, set 0

    txn(16'h00A8, 4'd3,  "R6 R13 wheel slot 0 shifted code");
    txn(16'h002C, 4'd5,  "R8 priority head");
    txn(16'h0084, 4'd2,  "R8 priority second");
    txn(16'h0280, 4'd7,  "R9 rr1 first");
    txn(16'h0280, 4'd9,  "R9 rr1 rotate");
    txn(16'h0280, 4'd7,  "R9 rr1 wrap");
    txn(16'h3080, 4'd12, "R10 gateway to rr2");
    txn(16'h3080, 4'd7,  "R10 rr1 pointer wrapped");
    txn(16'h3000, 4'd13, "R10 rr2 rotate");

    // R7 wheel walk through slot 127 and wrap to 0
    for (int k = 9; k <= 128; k++) begin
      logic [3:0] e;
      e = (k % 128 == 0) ? 4'd3 : (k % 128 == 127) ? 4'd4 : 4'd5;
      txn(16'h0038, e, $sformatf("R7 wheel step %0d", k));
    end

    // R12 write to inactive set
    wr(a_tbl(1'b1, 2'd0, 5'd0), 5'h16);
    txn(16'h0060, 4'd5, "R12 inactive set ignored");

    // R11 switch requested during active grant
    @(negedge clk); req = 16'h0060;
    wait_gnt();
    check(gnt_valid && gnt_id == 4'd5, "R11 grant before switch", int'(gnt_id), 5);
    wr(a_tbl(1'b0, 2'd3, 5'd0), 5'b00011);
    repeat (2) @(negedge clk);
    check(gnt_valid && gnt_id == 4'd5, "R11 R4 grant held over switch", int'(gnt_id), 5);
    finish_txn("R11");
    txn(16'h0060, 4'd6, "R11 set 1 after boundary");

    // back to boot, pointer kept at 3
    wr(a_tbl(1'b0, 2'd3, 5'd0), 5'b00001);
    txn(16'h0021, 4'd5, "R2 R11 boot resumes");
    txn(16'h0021, 4'd0, "R2 boot wrap");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule